// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a supervision timer that runs from the oscillator clock. Software has to prove that it is still running by writing a two-byte key to an arm port before the selected timeout expires. If the timeout expires, the block raises a reset request. A malformed key also raises a reset request. The reset generator that acts on the request lies outside this block.

The timeout is set by a 3-bit rate field in a 6-bit control word. Rate zero turns the watchdog off, and that is the state after reset. An optional windowed mode also treats a rearm that comes too early as a fault: any arm write before three quarters of the period has elapsed raises a reset request.

Two freeze options cover low-power and debug use:
- While wait mode is active and the wait-freeze option is set, the counter is held at zero.
- While debug is active and the debug-freeze option is set, the counter holds its value.

Top module: `wdt_core`

## Requirements
- R1: During reset and after it, `reset_req` is low. The control word resets to 6'h10: debug-freeze set, wait-freeze clear, window clear, rate 0. The watchdog is therefore disabled after reset.
- R2: The control word layout is as follows. Bit 5 enables the window. Bit 4 enables the debug freeze. Bit 3 enables the wait freeze. Bits 2:0 hold the rate. The period P in clock cycles is 2^(BASE_EXP+k), where k is 0, 2, 4, 6, 8, 9 and 10 for rates 1 to 7 (BASE_EXP defaults to 14).
- R3: With no valid rearm, `reset_req` is high in the cycle that follows the P-th counting clock edge after the last clear.
- R4: An arm write of 8'h55 followed by an arm write of 8'hAA restarts the count from zero, and no reset request results.
- R5: While enabled, an arm write of any value other than 8'h55 or 8'hAA raises `reset_req` on the next cycle. So does 8'hAA with no pending 8'h55.
- R6: In windowed mode, any arm write while the count is below 3P/4 raises `reset_req` on the next cycle. Writes from count 3P/4 up to P-1 are accepted. A rearm at count P-1 wins over the timeout.
- R7: A reset request lasts one cycle unless a new fault follows at once. The counter and the pending-key state then restart from their initial values.
- R8: A control write clears the counter and the pending-key state. An arm write in the same cycle as a control write is ignored.
- R9: While debug is active and the debug-freeze option is set, the counter holds its value and no timeout occurs.
- R10: While wait mode is active and the wait-freeze option is set, the counter is held at zero. This takes priority over the debug hold.
- R11: With rate 0, no timeout occurs and arm writes are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 6 | Control word: window, debug freeze, wait freeze, rate |
| arm_we | input | 1 | Arm port write strobe |
| arm_wdata | input | 8 | Arm key byte |
| wait_mode | input | 1 | System is in wait mode |
| debug_active | input | 1 | Debugger has halted the system |
| reset_req | output | 1 | One-cycle reset request |

## Verification
- **Timeout length:** every rate is allowed to expire unattended. Because both the no-reset and the reset cycles are checked, an off-by-one in period decode is caught.
- **Key sequences:** the correct pair, a foreign byte, a lone second byte, and a first byte followed by a foreign byte are each applied. Together they tell apart sequence tracking, value checking and the clearing of the pending state after a fault.
- **Window edges:** in windowed mode, writes are placed at count zero, one below the window, at its first count and at its last count. This pins the threshold and the order between rearm and timeout.
- **Freeze inputs:** debug and wait are held during a partly elapsed count. The resulting remaining time shows whether the count was held, zeroed or kept running.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   localparam logic [7:0] KEY_FIRST  = 8'h55;
   localparam logic [7:0] KEY_SECOND = 8'hAA;
   localparam int unsigned EXP_SPAN  = 10;

   typedef struct packed {
      logic       win_en;
      logic       dbg_freeze;
      logic       wait_freeze;
      logic [2:0] rate;
   } wdt_ctl_t;

   localparam wdt_ctl_t CTL_RESET = '{win_en: 1'b0, dbg_freeze: 1'b1,
                                      wait_freeze: 1'b0, rate: 3'd0};

   typedef enum logic {KEY_IDLE = 1'b0, KEY_HALF = 1'b1} key_state_e;

   function automatic int unsigned rate_exp(input int unsigned rate,
                                            input int unsigned base);
      case (rate)
         1:       return base;
         2:       return base + 2;
         3:       return base + 4;
         4:       return base + 6;
         5:       return base + 8;
         6:       return base + 9;
         7:       return base + 10;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/wdt_period.sv
module wdt_period #(
   parameter int unsigned BASE_EXP = 14,
   parameter int unsigned CW       = BASE_EXP + wdt_pkg::EXP_SPAN
) (
   input  logic [2:0]    rate,
   output logic          enabled,
   output logic [CW-1:0] last_cnt,
   output logic [CW-1:0] win_start
);
   logic [CW-1:0] last_tab [8];
   logic [CW-1:0] win_tab  [8];

   assign last_tab[0] = '0;
   assign win_tab[0]  = '0;

   for (genvar r = 1; r < 8; r++) begin : g_rate
      localparam int unsigned E = wdt_pkg::rate_exp(r, BASE_EXP);
      assign last_tab[r] = CW'((64'd1 << E) - 64'd1);
      assign win_tab[r]  = CW'((64'd1 << E) - (64'd1 << (E - 2)));
   end

   assign enabled   = (rate != 3'd0);
   assign last_cnt  = last_tab[rate];
   assign win_start = win_tab[rate];

endmodule

// File: rtl/wdt_key.sv
module wdt_key (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clr,
   input  logic       arm_ok,
   input  logic [7:0] arm_wdata,
   input  logic       win_en,
   input  logic       win_open,
   output logic       fault,
   output logic       rearm,
   output logic       key_half
);
   import wdt_pkg::*;

   key_state_e key_q;
   logic       bad_val;
   logic       early;
   logic       lone_second;

   always_comb begin
      bad_val     = (arm_wdata != KEY_FIRST) && (arm_wdata != KEY_SECOND);
      early       = win_en && !win_open;
      lone_second = (arm_wdata == KEY_SECOND) && (key_q == KEY_IDLE);
      fault       = arm_ok && (bad_val || early || lone_second);
      rearm       = arm_ok && !fault && (arm_wdata == KEY_SECOND);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= KEY_IDLE;
      end else if (clr || fault || rearm) begin
         key_q <= KEY_IDLE;
      end else if (arm_ok && arm_wdata == KEY_FIRST) begin
         key_q <= KEY_HALF;
      end
   end

   assign key_half = (key_q == KEY_HALF);

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
   parameter int unsigned CW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          enabled,
   input  logic          clear,
   input  logic          init,
   input  logic          hold,
   input  logic [CW-1:0] last_cnt,
   input  logic [CW-1:0] win_start,
   output logic [CW-1:0] cnt_q,
   output logic          timeout,
   output logic          win_open
);
   assign win_open = (cnt_q >= win_start);
   assign timeout  = enabled && !clear && !init && !hold && (cnt_q == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clear || init || !enabled || timeout) begin
         cnt_q <= '0;
      end else if (!hold) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
   parameter int unsigned BASE_EXP = 14
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic [5:0] ctl_wdata,
   input  logic       arm_we,
   input  logic [7:0] arm_wdata,
   input  logic       wait_mode,
   input  logic       debug_active,
   output logic       reset_req
);
   import wdt_pkg::*;

   localparam int unsigned CW = BASE_EXP + EXP_SPAN;

   if (BASE_EXP < 2 || BASE_EXP > 40) begin : g_bad_base
      $error("wdt_core: BASE_EXP must lie in 2..40");
   end

   wdt_ctl_t      ctl_q;
   logic          enabled;
   logic [CW-1:0] last_cnt;
   logic [CW-1:0] win_start;
   logic [CW-1:0] cnt_q;
   logic          timeout;
   logic          win_open;
   logic          fault;
   logic          rearm;
   logic          key_half;
   logic          arm_ok;
   logic          hold;
   logic          init;

   assign arm_ok = arm_we && enabled && !ctl_we;
   assign hold   = ctl_q.dbg_freeze && debug_active;
   assign init   = ctl_q.wait_freeze && wait_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= CTL_RESET;
      end else if (ctl_we) begin
         ctl_q <= wdt_ctl_t'(ctl_wdata);
      end
   end

   wdt_period #(.BASE_EXP(BASE_EXP), .CW(CW)) u_period (
      .rate      (ctl_q.rate),
      .enabled   (enabled),
      .last_cnt  (last_cnt),
      .win_start (win_start)
   );

   wdt_key u_key (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (ctl_we || timeout),
      .arm_ok    (arm_ok),
      .arm_wdata (arm_wdata),
      .win_en    (ctl_q.win_en),
      .win_open  (win_open),
      .fault     (fault),
      .rearm     (rearm),
      .key_half  (key_half)
   );

   wdt_count #(.CW(CW)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .enabled   (enabled),
      .clear     (ctl_we || fault || rearm),
      .init      (init),
      .hold      (hold),
      .last_cnt  (last_cnt),
      .win_start (win_start),
      .cnt_q     (cnt_q),
      .timeout   (timeout),
      .win_open  (win_open)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reset_req <= 1'b0;
      end else begin
         reset_req <= fault || timeout;
      end
   end

endmodule

// File: rtl/wdt_core_chk.sv
module wdt_core_chk #(
   parameter int unsigned CW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ctl_we,
   input logic          arm_we,
   input logic [7:0]    arm_wdata,
   input logic          wait_mode,
   input logic          debug_active,
   input logic          reset_req,
   input logic [5:0]    ctl_bits,
   input logic [CW-1:0] cnt_q,
   input logic [CW-1:0] last_cnt,
   input logic          key_half
);
   logic          on;
   logic          dbg_hold;
   logic          wait_init;
   logic [CW+2:0] p_ext;
   logic [CW+2:0] cnt_x4;
   logic [CW+2:0] p_x3;

   assign on        = (ctl_bits[2:0] != 3'd0);
   assign wait_init = wait_mode && ctl_bits[3];
   assign dbg_hold  = debug_active && ctl_bits[4];
   assign p_ext     = {3'b000, last_cnt} + 1'b1;
   assign cnt_x4    = {1'b0, cnt_q, 2'b00};
   assign p_x3      = p_ext + (p_ext << 1);

   // R11
   off_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_bits[2:0] == 3'd0) |=> !reset_req);

   // R5
   bad_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_we && !ctl_we && on && arm_wdata != 8'h55 && arm_wdata != 8'hAA) |=> reset_req);

   // R5
   lone_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_we && !ctl_we && on && arm_wdata == 8'hAA && !key_half) |=> reset_req);

   // R6
   early_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_we && !ctl_we && on && ctl_bits[5] && cnt_x4 < p_x3) |=> reset_req);

   // R3
   expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (on && cnt_q == last_cnt && !ctl_we && !arm_we && !dbg_hold && !wait_init) |=> reset_req);

   // R7
   pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |=> (!reset_req || $past(arm_we)));

   // R7
   restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reset_req |-> (cnt_q == '0 && !key_half));

   // R8
   ctl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_we |=> (cnt_q == '0 && !key_half));

   // R9
   dbg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dbg_hold && !wait_init && !ctl_we && !arm_we) |=> $stable(cnt_q));

   // R10
   wait_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_init && !ctl_we) |=> (cnt_q == '0));

endmodule

bind wdt_core wdt_core_chk #(.CW(CW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .ctl_we       (ctl_we),
   .arm_we       (arm_we),
   .arm_wdata    (arm_wdata),
   .wait_mode    (wait_mode),
   .debug_active (debug_active),
   .reset_req    (reset_req),
   .ctl_bits     (ctl_q),
   .cnt_q        (cnt_q),
   .last_cnt     (last_cnt),
   .key_half     (key_half)
);

// File: tb/wdt_core_bench.sv
`timescale 1ns/1ps
module wdt_core_bench;
   localparam int unsigned BASE = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_we = 1'b0;
   logic [5:0] ctl_wdata = '0;
   logic       arm_we = 1'b0;
   logic [7:0] arm_wdata = '0;
   logic       wait_mode = 1'b0;
   logic       debug_active = 1'b0;
   logic       reset_req;

   int n_vec = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   wdt_core #(.BASE_EXP(BASE)) u_wdt_core (
      .clk          (clk),
      .rst_n        (rst_n),
      .ctl_we       (ctl_we),
      .ctl_wdata    (ctl_wdata),
      .arm_we       (arm_we),
      .arm_wdata    (arm_wdata),
      .wait_mode    (wait_mode),
      .debug_active (debug_active),
      .reset_req    (reset_req)
   );

   function automatic int period(input int rate);
      int k [8] = '{0, 0, 2, 4, 6, 8, 9, 10};
      return 1 << (BASE + k[rate]);
   endfunction

   task automatic check(input logic exp, input string tag);
      n_vec++;
      if (reset_req !== exp) begin
         n_bad++;
         $display("FAIL %s: reset_req=%0b expected %0b", tag, reset_req, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ctl_write(input logic [5:0] v);
      ctl_we = 1'b1; ctl_wdata = v;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic arm_write(input logic [7:0] v);
      arm_we = 1'b1; arm_wdata = v;
      @(negedge clk);
      arm_we = 1'b0;
   endtask

   // Count restarted at the edge just before the current negedge.
   task automatic expect_timeout(input int p, input string tag);
      step(p - 1);
      check(1'b0, {tag, " before expiry"});
      step(1);
      check(1'b1, {tag, " at expiry"});
      step(1);
      check(1'b0, {tag, " pulse end"});
   endtask

   task automatic t_reset;
      check(1'b0, "R1 reset state");
      step(300);
      check(1'b0, "R11 disabled no timeout");
      arm_write(8'h33);
      check(1'b0, "R11 bad key ignored when off");
      arm_write(8'hAA);
      check(1'b0, "R11 lone key ignored when off");
   endtask

   task automatic t_rates;
      for (int r = 1; r < 8; r++) begin
         ctl_write(6'(r));
         expect_timeout(period(r), $sformatf("R2 R3 rate %0d", r));
      end
   endtask

   task automatic t_rearm;
      ctl_write(6'd1);
      for (int i = 0; i < 3; i++) begin
         step(10);
         arm_write(8'h55);
         check(1'b0, "R4 first key");
         arm_write(8'hAA);
         check(1'b0, "R4 second key");
      end
      expect_timeout(16, "R4 restart");
   endtask

   task automatic t_badkey;
      ctl_write(6'd1);
      step(3);
      arm_write(8'h33);
      check(1'b1, "R5 foreign byte");
      step(1);
      check(1'b0, "R7 one-cycle pulse");
      step(14);
      check(1'b0, "R7 restart before expiry");
      step(1);
      check(1'b1, "R7 restart expiry");
      ctl_write(6'd1);
      arm_write(8'hAA);
      check(1'b1, "R5 lone second key");
      ctl_write(6'd1);
      arm_write(8'h55);
      check(1'b0, "R5 first key alone");
      arm_write(8'h33);
      check(1'b1, "R5 foreign after first");
      arm_write(8'hAA);
      check(1'b1, "R7 pending key cleared by fault");
   endtask

   task automatic t_window;
      ctl_write(6'b100001);
      arm_write(8'h55);
      check(1'b1, "R6 write at count 0");
      ctl_write(6'b100001);
      step(11);
      arm_write(8'h55);
      check(1'b1, "R6 write one below window");
      ctl_write(6'b100001);
      step(12);
      arm_write(8'h55);
      check(1'b0, "R6 write at window start");
      arm_write(8'hAA);
      check(1'b0, "R6 rearm in window");
      expect_timeout(16, "R6 after window rearm");
      ctl_write(6'b100001);
      step(14);
      arm_write(8'h55);
      check(1'b0, "R6 first key at count 14");
      arm_write(8'hAA);
      check(1'b0, "R6 rearm at last count");
      expect_timeout(16, "R6 after last-count rearm");
   endtask

   task automatic t_ctl;
      ctl_write(6'd1);
      step(10);
      ctl_write(6'd1);
      expect_timeout(16, "R8 control write clears");
      ctl_we = 1'b1; ctl_wdata = 6'd1;
      arm_we = 1'b1; arm_wdata = 8'h33;
      @(negedge clk);
      ctl_we = 1'b0; arm_we = 1'b0;
      check(1'b0, "R8 simultaneous arm ignored");
      expect_timeout(16, "R8 after simultaneous write");
   endtask

   task automatic t_debug;
      ctl_write(6'b010001);
      step(5);
      debug_active = 1'b1;
      step(50);
      check(1'b0, "R9 frozen no timeout");
      debug_active = 1'b0;
      expect_timeout(11, "R9 count resumed");
      ctl_write(6'd1);
      debug_active = 1'b1;
      expect_timeout(16, "R9 freeze bit clear");
      debug_active = 1'b0;
   endtask

   task automatic t_wait;
      ctl_write(6'b001001);
      step(10);
      wait_mode = 1'b1;
      step(40);
      check(1'b0, "R10 wait no timeout");
      wait_mode = 1'b0;
      expect_timeout(16, "R10 count initialized");
      ctl_write(6'b011001);
      step(10);
      wait_mode = 1'b1; debug_active = 1'b1;
      step(20);
      wait_mode = 1'b0; debug_active = 1'b0;
      expect_timeout(16, "R10 wait over debug");
      ctl_write(6'd1);
      wait_mode = 1'b1;
      expect_timeout(16, "R10 wait bit clear");
      wait_mode = 1'b0;
   endtask

   initial begin
      #1_000_000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      step(4);
      rst_n = 1'b1;
      step(1);
      t_reset();
      t_rates();
      t_rearm();
      t_badkey();
      t_window();
      t_ctl();
      t_debug();
      t_wait();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule